// File: doc/BRIEF.md
# Single-Bit Shift and Rotate Execution Unit

This unit carries out the four one-position shift and rotate operations of an 8-bit accumulator processor. The operations are shift left, shift right, rotate left through carry and rotate right through carry. The caller presents an opcode byte, a ready effective address, the current accumulator value and the current carry, then pulses `start`. The unit decodes the opcode to find the operation and the operand location. It then runs for exactly the number of clock cycles that the instruction takes on the processor. When it finishes, it publishes the new negative, zero and carry flags. It also reports the instruction length in bytes and its cycle count.

When the operand is the accumulator, the result goes to `acc_out` and the memory port stays quiet. When the operand is in memory, the unit performs a read-modify-write on a synchronous byte-wide port. Read data appears the cycle after a read strobe. The original byte is written back once, and the modified byte is written on the final cycle, both to the same address. An opcode outside the supported set produces a one-cycle `illegal` pulse and nothing else.

Top module: `shift_rot_unit`

## Requirements
- R1: Shift left (opcode bits [6:5] = 00): the result is the operand moved up one place with 0 entering bit 0, and the carry out is the old bit 7.
- R2: Rotate left (bits [6:5] = 01): like R1, but the incoming carry enters bit 0.
- R3: Shift right (bits [6:5] = 10): the result is the operand moved down one place with 0 entering bit 7, so N is always 0, and the carry out is the old bit 0.
- R4: Rotate right (bits [6:5] = 11): like R3, but the incoming carry enters bit 7.
- R5: `flag_n` equals result bit 7, `flag_z` is 1 exactly when the result is 0, and `flag_c` is the carry out. All three take their new values in the cycle in which `done` is high.
- R6: Opcode map. Bit 7 must be 0. The low five bits select the operand form: 0x0A accumulator, 0x06 zero page, 0x16 zero page indexed, 0x0E absolute, 0x1E absolute indexed. This gives 20 legal opcodes. The accumulator forms take 1 byte and 2 cycles.
- R7: From the cycle after `start`, `len_cycles` and `len_bytes` show the instruction's cost: zero page 5/2, zero page indexed 6/2, absolute 6/3, absolute indexed 7/3.
- R8: After an accepted `start`, `busy` is high for exactly `len_cycles` consecutive cycles, and `done` is high only in the last of them.
- R9: Memory forms perform these accesses, counting busy cycles from 1 to N:
  - a read in cycle N-3;
  - a write of the unmodified byte in cycle N-1;
  - a write of the result in cycle N, to the same address.
  Accumulator forms make no memory access.
- R10: Zero-page forms drive 0 on address bits [15:8], whatever `ea` holds there. Absolute forms drive all 16 bits of `ea`.
- R11: `acc_out` is updated only by accumulator forms. Memory forms leave it unchanged.
- R12: A `start` with an undefined opcode raises `illegal` for exactly the next cycle. It does not raise `busy`, and it leaves `acc_out` and the flags unchanged.
- R13: A `start` that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch request, sampled at the rising edge |
| opcode | input | 8 | Instruction opcode byte |
| ea | input | 16 | Ready effective address of the memory operand |
| acc_in | input | 8 | Accumulator value used by accumulator forms |
| carry_in | input | 1 | Carry value before the instruction |
| busy | output | 1 | High for the whole cycle count of the instruction |
| done | output | 1 | High in the final cycle of the instruction |
| illegal | output | 1 | One-cycle pulse after a start with an undefined opcode |
| len_bytes | output | 2 | Instruction length in bytes |
| len_cycles | output | 3 | Instruction duration in cycles |
| acc_out | output | 8 | Accumulator result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Memory read strobe; data is returned the next cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |

## Verification
Each operation is driven with these operands, with carry-in both 0 and 1:
- 0x00 and 0x01 show whether the zero flag follows the result and whether a set low bit leaves through the carry;
- 0x80 does the same for the top bit and shows the incoming carry entering the far end;
- 0x55 and 0xFF catch a wrong shift direction or a bit lost in the middle.

Every memory form is run with distinct bytes at distinct addresses, so a write to the wrong address or out of order shows up in the memory image. A zero-page form is given a nonzero high address byte to show that the page is forced to zero. Undefined opcodes and a start issued in mid-instruction show whether stray requests disturb the outputs.

// File: rtl/srt_pkg.sv
// Package: shared types for the shift/rotate execution unit.
// Assumes the opcode bits [6:5] select the operation directly.
package srt_pkg;

    // Operation selected by opcode bits [6:5]
    typedef enum logic [1:0] {
        OP_SHL  = 2'b00,
        OP_ROTL = 2'b01,
        OP_SHR  = 2'b10,
        OP_ROTR = 2'b11
    } shop_e;

    // Operand location
    typedef enum logic [2:0] {
        AM_ACC  = 3'd0,
        AM_ZP   = 3'd1,
        AM_ZPX  = 3'd2,
        AM_ABS  = 3'd3,
        AM_ABSX = 3'd4
    } amode_e;

    // Decoded instruction
    typedef struct packed {
        logic       legal;
        shop_e      op;
        amode_e     mode;
        logic [1:0] nbytes;
        logic [2:0] ncyc;
    } decode_t;

endpackage

// File: rtl/srt_decode.sv
// Module: srt_decode
// Maps an opcode byte to operation, operand form, byte length and cycle
// count. Purely combinational. Assumes bit 7 = 0 for every legal opcode.
module srt_decode
    import srt_pkg::*;
(
    input  logic [7:0] opcode,
    output decode_t    dec
);

    // Decode the low five bits to an operand form and its cost
    always_comb begin
        dec        = '0;
        dec.op     = shop_e'(opcode[6:5]);
        dec.mode   = AM_ACC;
        if (!opcode[7]) begin
            case (opcode[4:0])
                5'h0A: begin dec.legal = 1'b1; dec.mode = AM_ACC;  dec.nbytes = 2'd1; dec.ncyc = 3'd2; end
                5'h06: begin dec.legal = 1'b1; dec.mode = AM_ZP;   dec.nbytes = 2'd2; dec.ncyc = 3'd5; end
                5'h16: begin dec.legal = 1'b1; dec.mode = AM_ZPX;  dec.nbytes = 2'd2; dec.ncyc = 3'd6; end
                5'h0E: begin dec.legal = 1'b1; dec.mode = AM_ABS;  dec.nbytes = 2'd3; dec.ncyc = 3'd6; end
                5'h1E: begin dec.legal = 1'b1; dec.mode = AM_ABSX; dec.nbytes = 2'd3; dec.ncyc = 3'd7; end
                default: dec.legal = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/srt_alu.sv
// Module: srt_alu
// One-position shift/rotate of a W-bit value with carry in and out, plus
// the sign and zero indications of the result. Combinational.
module srt_alu
    import srt_pkg::*;
#(
    parameter int W = 8
) (
    input  shop_e          op,
    input  logic [W-1:0]   a,
    input  logic           cin,
    output logic [W-1:0]   res,
    output logic           cout,
    output logic           neg,
    output logic           zero
);

    // Select the bit that enters the vacated end
    always_comb begin
        case (op)
            OP_SHL:  {cout, res} = {a, 1'b0};
            OP_ROTL: {cout, res} = {a, cin};
            OP_SHR:  {res, cout} = {1'b0, a};
            default: {res, cout} = {cin, a};
        endcase
    end

    // Result indications
    always_comb begin
        neg  = res[W-1];
        zero = ~|res;
    end

endmodule

// File: rtl/srt_seq.sv
// Module: srt_seq
// Down-counter that times one instruction. Loaded with the cycle count on
// launch; its value names the phase of the read-modify-write sequence.
// Assumes the load value is at least 2.
module srt_seq #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic [CNT_W-1:0] load_cnt,
    output logic             busy,
    output logic             ph_read,
    output logic             ph_capture,
    output logic             ph_wold,
    output logic             ph_last
);

    localparam logic [CNT_W-1:0] CNT_READ = CNT_W'(4);
    localparam logic [CNT_W-1:0] CNT_CAP  = CNT_W'(3);
    localparam logic [CNT_W-1:0] CNT_WOLD = CNT_W'(2);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

    logic [CNT_W-1:0] cnt;

    // Count the remaining cycles of the instruction
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (launch)     cnt <= load_cnt;
        else if (cnt != '0)  cnt <= cnt - CNT_W'(1);
    end

    // Phase decode from the remaining-cycle count
    always_comb begin
        busy       = (cnt != '0);
        ph_read    = (cnt == CNT_READ);
        ph_capture = (cnt == CNT_CAP);
        ph_wold    = (cnt == CNT_WOLD);
        ph_last    = (cnt == CNT_LAST);
    end

endmodule

// File: rtl/shift_rot_unit.sv
// Module: shift_rot_unit
// Executes the 20 single-bit shift/rotate opcodes on the accumulator or
// on a memory byte, with cycle-exact read-modify-write timing.
// Assumes the effective address is ready at start and that memory read data
// returns one cycle after the read strobe.
module shift_rot_unit
    import srt_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [ADDR_W-1:0] ea,
    input  logic [DATA_W-1:0] acc_in,
    input  logic              carry_in,
    output logic              busy,
    output logic              done,
    output logic              illegal,
    output logic [1:0]        len_bytes,
    output logic [CNT_W-1:0]  len_cycles,
    output logic [DATA_W-1:0] acc_out,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_c,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int PAGE_W = 8;
    localparam int HIGH_W = ADDR_W - PAGE_W;

    decode_t           dec;
    logic              launch;
    logic              ph_read, ph_capture, ph_wold, ph_last;
    shop_e             op_q;
    logic              is_mem_q, zp_q, cin_q, illegal_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] opnd_q, res_q;
    logic [DATA_W-1:0] alu_res;
    logic              alu_cout, alu_neg, alu_zero;

    srt_decode u_dec (
        .opcode (opcode),
        .dec    (dec)
    );

    // Accept a request only when idle and the opcode is defined
    always_comb launch = start && !busy && dec.legal;

    srt_seq #(.CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .load_cnt   (CNT_W'(dec.ncyc)),
        .busy       (busy),
        .ph_read    (ph_read),
        .ph_capture (ph_capture),
        .ph_wold    (ph_wold),
        .ph_last    (ph_last)
    );

    srt_alu #(.W(DATA_W)) u_alu (
        .op   (op_q),
        .a    (opnd_q),
        .cin  (cin_q),
        .res  (alu_res),
        .cout (alu_cout),
        .neg  (alu_neg),
        .zero (alu_zero)
    );

    // Latch the instruction context on launch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q       <= OP_SHL;
            is_mem_q   <= 1'b0;
            zp_q       <= 1'b0;
            cin_q      <= 1'b0;
            addr_q     <= '0;
            len_bytes  <= '0;
            len_cycles <= '0;
        end else if (launch) begin
            op_q       <= dec.op;
            is_mem_q   <= (dec.mode != AM_ACC);
            zp_q       <= (dec.mode == AM_ZP) || (dec.mode == AM_ZPX);
            cin_q      <= carry_in;
            addr_q     <= ea;
            len_bytes  <= dec.nbytes;
            len_cycles <= CNT_W'(dec.ncyc);
        end
    end

    // Operand register: accumulator on launch, memory byte on capture
    always_ff @(posedge clk) begin
        if (!rst_n)                       opnd_q <= '0;
        else if (launch)                  opnd_q <= acc_in;
        else if (ph_capture && is_mem_q)  opnd_q <= mem_rdata;
    end

    // Result and flags take effect entering the final cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q   <= '0;
            acc_out <= '0;
            flag_n  <= 1'b0;
            flag_z  <= 1'b0;
            flag_c  <= 1'b0;
        end else if (ph_wold) begin
            res_q  <= alu_res;
            flag_n <= alu_neg;
            flag_z <= alu_zero;
            flag_c <= alu_cout;
            if (!is_mem_q) acc_out <= alu_res;
        end
    end

    // One-cycle pulse for a rejected opcode
    always_ff @(posedge clk) begin
        if (!rst_n) illegal_q <= 1'b0;
        else        illegal_q <= start && !busy && !dec.legal;
    end

    // Drive completion and the memory port from the phase
    always_comb begin
        illegal   = illegal_q;
        done      = ph_last;
        mem_rd    = is_mem_q && ph_read;
        mem_we    = is_mem_q && (ph_wold || ph_last);
        mem_wdata = ph_wold ? opnd_q : res_q;
        mem_addr  = zp_q ? {{HIGH_W{1'b0}}, addr_q[PAGE_W-1:0]} : addr_q;
    end

endmodule

// File: rtl/shift_rot_unit_chk.sv
// Module: shift_rot_unit_chk
// Temporal checks on the shift/rotate unit's ports, bound to every instance.
module shift_rot_unit_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              illegal,
    input logic [1:0]        len_bytes,
    input logic [CNT_W-1:0]  len_cycles,
    input logic [DATA_W-1:0] acc_out,
    input logic              flag_n,
    input logic              flag_z,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd,
    input logic              mem_we,
    input logic [DATA_W-1:0] mem_wdata
);

    a_r8_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    a_r8_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_write_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !done) |=> (mem_we && done && $stable(mem_addr)));

    a_r9_no_rd_we: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_we));

    a_r5_mem_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mem_we) |-> (flag_n == mem_wdata[DATA_W-1] && flag_z == (mem_wdata == '0)));

    a_r5_acc_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !mem_we) |-> (flag_n == acc_out[DATA_W-1] && flag_z == (acc_out == '0)));

    a_r10_zero_page: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd || mem_we) && len_bytes == 2'd2) |-> (mem_addr[ADDR_W-1:8] == '0));

    a_r12_illegal_idle: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !busy);

    a_r7_min_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (len_cycles >= CNT_W'(2)));

endmodule

bind shift_rot_unit shift_rot_unit_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .illegal    (illegal),
    .len_bytes  (len_bytes),
    .len_cycles (len_cycles),
    .acc_out    (acc_out),
    .flag_n     (flag_n),
    .flag_z     (flag_z),
    .mem_addr   (mem_addr),
    .mem_rd     (mem_rd),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata)
);

// File: tb/shift_rot_unit_test.sv
// Directed bench for shift_rot_unit: one task per scenario, each checking
// its own results against a model written from the requirements.
module shift_rot_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [15:0] ea = 16'h0000;
    logic [7:0]  acc_in = 8'h00;
    logic        carry_in = 1'b0;
    logic        busy, done, illegal;
    logic [1:0]  len_bytes;
    logic [2:0]  len_cycles;
    logic [7:0]  acc_out;
    logic        flag_n, flag_z, flag_c;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_we;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;
    logic [7:0]  mem [0:255];

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    shift_rot_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .ea(ea),
        .acc_in(acc_in), .carry_in(carry_in), .busy(busy), .done(done),
        .illegal(illegal), .len_bytes(len_bytes), .len_cycles(len_cycles),
        .acc_out(acc_out), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Synchronous byte memory indexed by the low address byte
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Model: returns {carry_out, result}
    function automatic logic [8:0] model(input logic [1:0] op, input logic [7:0] v,
                                         input logic cin);
        case (op)
            2'b00:   return {v[7], v[6:0], 1'b0};        // R1
            2'b01:   return {v[7], v[6:0], cin};         // R2
            2'b10:   return {v[0], 1'b0, v[7:1]};        // R3
            default: return {v[0], cin, v[7:1]};         // R4
        endcase
    endfunction

    function automatic string op_req(input logic [1:0] op);
        case (op)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    // Run one legal instruction and check every observable effect
    task automatic run_op(input logic [7:0] opc, input logic [15:0] addr,
                          input logic [7:0] acc, input logic cin,
                          input logic [7:0] mval);
        int          ncyc, nbyt, k, rdk, w1k, w2k, dk, lb, lc;
        logic        is_mem, zp;
        logic [15:0] exp_addr, a_rd, a_w1, a_w2;
        logic [7:0]  d_w1, d_w2, prev_acc, opnd, fz_acc;
        logic [8:0]  m;
        logic        fn, fz, fc;
        string       rq;
        case (opc[4:0])
            5'h0A:   begin ncyc = 2; nbyt = 1; end
            5'h06:   begin ncyc = 5; nbyt = 2; end
            5'h16:   begin ncyc = 6; nbyt = 2; end
            5'h0E:   begin ncyc = 6; nbyt = 3; end
            default: begin ncyc = 7; nbyt = 3; end
        endcase
        is_mem   = (opc[4:0] != 5'h0A);
        zp       = (nbyt == 2);
        exp_addr = zp ? {8'h00, addr[7:0]} : addr;
        @(negedge clk);
        if (is_mem) mem[exp_addr[7:0]] = mval;
        prev_acc = acc_out;
        opnd     = is_mem ? mval : acc;
        m        = model(opc[6:5], opnd, cin);
        rq       = op_req(opc[6:5]);
        opcode = opc; ea = addr; acc_in = acc; carry_in = cin; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 0; rdk = 0; w1k = 0; w2k = 0; dk = 0; lb = 0; lc = 0;
        a_rd = '0; a_w1 = '0; a_w2 = '0; d_w1 = '0; d_w2 = '0;
        fn = 0; fz = 0; fc = 0; fz_acc = '0;
        while (busy && k < 12) begin
            k++;
            if (k == 1) begin lb = len_bytes; lc = len_cycles; end
            if (mem_rd) begin rdk = k; a_rd = mem_addr; end
            if (mem_we) begin
                if (w1k == 0) begin w1k = k; a_w1 = mem_addr; d_w1 = mem_wdata; end
                else          begin w2k = k; a_w2 = mem_addr; d_w2 = mem_wdata; end
            end
            if (done) begin
                dk = k; fn = flag_n; fz = flag_z; fc = flag_c; fz_acc = acc_out;
            end
            @(negedge clk);
        end
        chk(k == ncyc, "R8", "busy cycles", k, ncyc);
        chk(dk == ncyc, "R8", "done cycle", dk, ncyc);
        chk(lc == ncyc, is_mem ? "R7" : "R6", "len_cycles", lc, ncyc);
        chk(lb == nbyt, is_mem ? "R7" : "R6", "len_bytes", lb, nbyt);
        chk(fc == m[8], rq, "carry out", fc, m[8]);
        chk(fn == m[7], "R5", "flag_n", fn, m[7]);
        chk(fz == (m[7:0] == 8'h00), "R5", "flag_z", fz, (m[7:0] == 8'h00));
        if (opc[6:5] == 2'b10) chk(fn == 1'b0, "R3", "N after shift right", fn, 0);
        if (is_mem) begin
            chk(rdk == ncyc - 3, "R9", "read cycle", rdk, ncyc - 3);
            chk(w1k == ncyc - 1, "R9", "first write cycle", w1k, ncyc - 1);
            chk(w2k == ncyc, "R9", "second write cycle", w2k, ncyc);
            chk(d_w1 == mval, "R9", "first write data", d_w1, mval);
            chk(d_w2 == m[7:0], rq, "memory result", d_w2, m[7:0]);
            chk(a_rd == exp_addr && a_w1 == exp_addr && a_w2 == exp_addr,
                zp ? "R10" : "R9", "address", a_w2, exp_addr);
            chk(mem[exp_addr[7:0]] == m[7:0], "R9", "memory image", mem[exp_addr[7:0]], m[7:0]);
            chk(fz_acc == prev_acc, "R11", "acc_out unchanged", fz_acc, prev_acc);
        end else begin
            chk(rdk == 0 && w1k == 0, "R9", "no memory access", rdk + w1k, 0);
            chk(fz_acc == m[7:0], rq, "acc result", fz_acc, m[7:0]);
        end
    endtask

    task automatic t_reset();
        chk(!busy && !done && !illegal, "R8", "reset control", {busy, done, illegal}, 0);
        chk(!mem_rd && !mem_we, "R9", "reset memory strobes", {mem_rd, mem_we}, 0);
        chk(acc_out == 8'h00 && !flag_n && !flag_z && !flag_c, "R5", "reset state",
            {acc_out, flag_n, flag_z, flag_c}, 0);
    endtask

    // R1 R2 R3 R4 R6: accumulator forms over boundary operands and both carries
    task automatic t_acc_forms();
        logic [7:0] pats [5] = '{8'h00, 8'h01, 8'h80, 8'h55, 8'hFF};
        for (int o = 0; o < 4; o++)
            for (int p = 0; p < 5; p++)
                for (int c = 0; c < 2; c++)
                    run_op({1'b0, 2'(o), 5'h0A}, 16'h0000, pats[p], c[0], 8'h00);
    endtask

    // R7 R9 R11: all sixteen memory forms with distinct addresses and data
    task automatic t_mem_forms();
        logic [4:0]  lows  [4] = '{5'h06, 5'h16, 5'h0E, 5'h1E};
        logic [15:0] addrs [4] = '{16'h0031, 16'h00F2, 16'h12A3, 16'hBE04};
        logic [7:0]  vals  [4] = '{8'h81, 8'h01, 8'h7E, 8'h00};
        for (int o = 0; o < 4; o++)
            for (int f = 0; f < 4; f++)
                for (int c = 0; c < 2; c++)
                    run_op({1'b0, 2'(o), lows[f]}, addrs[f] + 16'(o * 8),
                           vals[(f + o) % 4] ^ 8'(c * 8'h5A), c[0], vals[(f + o) % 4] ^ 8'(c * 8'h5A));
    endtask

    // R10: zero-page forms with a nonzero high address byte
    task automatic t_zp_page();
        run_op(8'h06, 16'hAB40, 8'h00, 1'b0, 8'hC3);
        run_op(8'h76, 16'h7F41, 8'h00, 1'b1, 8'h02);
    endtask

    // R12: undefined opcodes leave everything unchanged
    task automatic t_illegal();
        logic [7:0] bad [4] = '{8'h0B, 8'h8A, 8'h1A, 8'hA6};
        for (int i = 0; i < 4; i++) begin
            logic [7:0] a0;
            logic [2:0] f0;
            @(negedge clk);
            a0 = acc_out; f0 = {flag_n, flag_z, flag_c};
            opcode = bad[i]; acc_in = 8'h3C; carry_in = 1'b1; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(illegal && !busy, "R12", "illegal pulse", {illegal, busy}, 2'b10);
            @(negedge clk);
            chk(!illegal && !busy, "R12", "pulse length", {illegal, busy}, 0);
            chk(acc_out == a0 && {flag_n, flag_z, flag_c} == f0, "R12", "state kept",
                {acc_out, flag_n, flag_z, flag_c}, {a0, f0});
        end
    endtask

    // R13: a second start during busy is ignored
    task automatic t_start_busy();
        int k;
        @(negedge clk);
        opcode = 8'h0E; ea = 16'h0050; carry_in = 1'b0; start = 1'b1;
        mem[8'h50] = 8'h21;
        @(negedge clk);
        opcode = 8'h6A; acc_in = 8'h99; carry_in = 1'b1;   // start still high
        k = 0;
        while (busy && k < 12) begin
            k++;
            @(negedge clk);
        end
        start = 1'b0;
        chk(k == 6, "R13", "busy length with repeated start", k, 6);
        chk(mem[8'h50] == 8'h42, "R13", "first instruction result", mem[8'h50], 8'h42);
        chk(!busy && !illegal, "R13", "no second launch", {busy, illegal}, 0);
        @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: actual hang expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_acc_forms();
        t_mem_forms();
        t_zp_page();
        t_illegal();
        t_start_busy();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule